// File: doc/BRIEF.md
# PC-Indexed L1 Bypass Predictor

This block decides, for each L1 data-cache miss, whether the returning line should be installed in the cache or handed straight to the requesting compute unit and dropped. The decision comes from a small table of 4-bit saturating counters. Each entry is selected by a 6-bit fold of the load instruction's PC plus the lowest set-index bit of the address. The table is read combinationally in the lookup cycle, alongside the tag lookup, so the prediction is ready as soon as hit or miss is known.

The table learns from line lifetimes. Each resident line carries 7 bits of metadata: a reuse flag in bit 6 and the 6-bit PC hash in bits 5:0. A line evicted without any reuse pushes its PC's counter up. A hit pushes the counter down and returns the line metadata with the reuse flag set, for writeback into the tag. The next-level cache keeps one flag per line, which marks lines that were forwarded without an L1 fill. When a fill comes back with that flag set, the earlier bypass was wrong. The counter then drops by two and the line is installed. The miss-tracking logic carries the lookup-time prediction to the fill.

Top module: `bypassPredictor`

## Requirements
- R1: After reset every counter is 0, so no lookup predicts bypass until the table has been trained.
- R2: The table index is {addr[6], h}. The hash h is the XOR of PC[7:2], PC[13:8], PC[19:14], PC[25:20] and PC[31:26]. predBypass is 1 in the same cycle exactly when lookupValid is high and the indexed counter is 8 or more.
- R3: An eviction whose metadata has bit 6 (reuse) clear raises the counter at {evictAddr[6], evictMeta[5:0]} by one, with a ceiling of 15. An eviction with reuse set changes nothing.
- R4: A lookup that hits lowers the counter at {lookupAddr[6], hitMeta[5:0]} by one, with a floor of 0. lineMetaUpd equals hitMeta[5:0] with bit 6 set.
- R5: A fill with fillNlBypassBit set lowers the counter at {fillAddr[6], hash of fillPc} by two, with a floor of 0.
- R6: On a fill, fillForwardOnly = fillPredBypass and not fillNlBypassBit, and fillWrite is its complement. fillMeta is {0, hash of fillPc}. With fillValid low, both routing outputs are 0.
- R7: nlMarkValid follows fillValid. nlMarkSet (set the next-level flag) is 1 exactly for forward-only fills. A write fill asks the next level to clear the flag.
- R8: Counter updates take effect at the next clock edge. Events in one cycle that target the same entry combine into one net change before saturation.
- R9: The same PC with addr[6] = 0 and addr[6] = 1 uses two separate counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | L1 lookup in this cycle |
| lookupPc | input | 32 | PC of the load |
| lookupAddr | input | 32 | Byte address of the load |
| lookupHit | input | 1 | Tag lookup result for this cycle |
| hitMeta | input | 7 | Metadata of the hitting line |
| predBypass | output | 1 | Prediction: bypass on miss |
| lineMetaUpd | output | 7 | Hitting line metadata with reuse set |
| evictValid | input | 1 | A line is being evicted |
| evictAddr | input | 32 | Address of the evicted line |
| evictMeta | input | 7 | Metadata of the evicted line |
| fillValid | input | 1 | Line returned from next level |
| fillPc | input | 32 | PC of the miss being filled |
| fillAddr | input | 32 | Address of the returned line |
| fillPredBypass | input | 1 | Prediction taken at lookup |
| fillNlBypassBit | input | 1 | Next-level flag found set on this line |
| fillWrite | output | 1 | Install line into L1 arrays |
| fillForwardOnly | output | 1 | Forward to requester only |
| fillMeta | output | 7 | Metadata for the installed line |
| nlMarkValid | output | 1 | Update next-level flag |
| nlMarkSet | output | 1 | Value for the next-level flag |

## Verification
Three kinds of counter training are tested. Runs of evictions without reuse show the threshold crossing at the eighth step and the ceiling at 15. Runs of hits, and evictions with reuse set, show the decrement and that a reused line trains nothing. Starting from 0 or 1, hits and mispredict fills tell a saturating floor apart from wraparound: after such an underflow, exactly seven evictions must still predict no bypass. Events that land on one entry in the same cycle check the net update. PCs chosen to collide or differ under the XOR fold, and addresses that differ only in bit 6, check the index. All four fill flag combinations check routing and the next-level update.

// File: rtl/bpPkg.sv
package bpPkg;
  localparam int PC_W       = 32;
  localparam int ADDR_W     = 32;
  localparam int HASH_W     = 6;
  localparam int CTR_W      = 4;
  localparam int LINE_OFF_W = 6;
  localparam int PC_ALIGN   = 2;
  localparam int IDX_W      = HASH_W + 1;
  localparam int ENTRIES    = 1 << IDX_W;
  localparam int META_W     = HASH_W + 1;
  localparam int REUSE_BIT  = HASH_W;

  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    logic incEn;
    idx_t incIdx;
    logic decEn;
    idx_t decIdx;
    logic dropEn;
    idx_t dropIdx;
  } updStrobe_t;

  function automatic logic [HASH_W-1:0] foldPc(input logic [PC_W-1:0] pc);
    logic [HASH_W-1:0] h;
    h = '0;
    for (int b = PC_ALIGN; b < PC_W; b++) h[(b - PC_ALIGN) % HASH_W] ^= pc[b];
    return h;
  endfunction
endpackage

// File: rtl/bypassTable.sv
module bypassTable
  import bpPkg::*;
#(
  parameter int THRESH = 1 << (CTR_W - 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  idx_t       rdIdx,
  output logic       rdBypass,
  input  updStrobe_t upd
);
  localparam int SUM_W = CTR_W + 3;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << CTR_W) - 1);
  localparam logic signed [SUM_W-1:0] ONE  = SUM_W'(1);
  localparam logic signed [SUM_W-1:0] TWO  = SUM_W'(2);
  localparam logic signed [SUM_W-1:0] ZERO = '0;

  logic [CTR_W-1:0] ctr [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic signed [SUM_W-1:0] nextVal;
    always_comb begin
      nextVal = $signed({3'b000, ctr[e]});
      if (upd.incEn  && upd.incIdx  == idx_t'(e)) nextVal = nextVal + ONE;
      if (upd.decEn  && upd.decIdx  == idx_t'(e)) nextVal = nextVal - ONE;
      if (upd.dropEn && upd.dropIdx == idx_t'(e)) nextVal = nextVal - TWO;
      if (nextVal < ZERO) nextVal = ZERO;
      else if (nextVal > MAXV) nextVal = MAXV;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ctr[e] <= '0;
      else       ctr[e] <= nextVal[CTR_W-1:0];
    end
  end

  assign rdBypass = (ctr[rdIdx] >= CTR_W'(THRESH));
endmodule

// File: rtl/bypassCtrl.sv
module bypassCtrl
  import bpPkg::*;
(
  input  logic              lookupValid,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              lookupHit,
  input  logic [META_W-1:0] hitMeta,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [META_W-1:0] evictMeta,
  input  logic              fillValid,
  input  logic [PC_W-1:0]   fillPc,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic              fillPredBypass,
  input  logic              fillNlBypassBit,
  output idx_t              rdIdx,
  output updStrobe_t        upd,
  output logic [META_W-1:0] lineMetaUpd,
  output logic              fillWrite,
  output logic              fillForwardOnly,
  output logic [META_W-1:0] fillMeta,
  output logic              nlMarkValid,
  output logic              nlMarkSet
);
  logic [HASH_W-1:0] fillHash;
  logic              forwardOnly;
  logic              unusedBits;

  assign rdIdx    = {lookupAddr[LINE_OFF_W], foldPc(lookupPc)};
  assign fillHash = foldPc(fillPc);

  always_comb begin
    upd         = '0;
    upd.decEn   = lookupValid & lookupHit;
    upd.decIdx  = {lookupAddr[LINE_OFF_W], hitMeta[HASH_W-1:0]};
    upd.incEn   = evictValid & ~evictMeta[REUSE_BIT];
    upd.incIdx  = {evictAddr[LINE_OFF_W], evictMeta[HASH_W-1:0]};
    upd.dropEn  = fillValid & fillNlBypassBit;
    upd.dropIdx = {fillAddr[LINE_OFF_W], fillHash};
  end

  assign lineMetaUpd     = {1'b1, hitMeta[HASH_W-1:0]};
  assign forwardOnly     = fillValid & fillPredBypass & ~fillNlBypassBit;
  assign fillForwardOnly = forwardOnly;
  assign fillWrite       = fillValid & ~forwardOnly;
  assign fillMeta        = {1'b0, fillHash};
  assign nlMarkValid     = fillValid;
  assign nlMarkSet       = forwardOnly;

  assign unusedBits = ^{lookupAddr, evictAddr, fillAddr, hitMeta[REUSE_BIT]};
endmodule

// File: rtl/bypassPredictor.sv
module bypassPredictor
  import bpPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [PC_W-1:0]   lookupPc,
  input  logic [ADDR_W-1:0] lookupAddr,
  input  logic              lookupHit,
  input  logic [META_W-1:0] hitMeta,
  output logic              predBypass,
  output logic [META_W-1:0] lineMetaUpd,
  input  logic              evictValid,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [META_W-1:0] evictMeta,
  input  logic              fillValid,
  input  logic [PC_W-1:0]   fillPc,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic              fillPredBypass,
  input  logic              fillNlBypassBit,
  output logic              fillWrite,
  output logic              fillForwardOnly,
  output logic [META_W-1:0] fillMeta,
  output logic              nlMarkValid,
  output logic              nlMarkSet
);
  idx_t       rdIdx;
  updStrobe_t upd;
  logic       rdBypass;

  bypassCtrl u_ctrl (
    .lookupValid(lookupValid), .lookupPc(lookupPc), .lookupAddr(lookupAddr),
    .lookupHit(lookupHit), .hitMeta(hitMeta),
    .evictValid(evictValid), .evictAddr(evictAddr), .evictMeta(evictMeta),
    .fillValid(fillValid), .fillPc(fillPc), .fillAddr(fillAddr),
    .fillPredBypass(fillPredBypass), .fillNlBypassBit(fillNlBypassBit),
    .rdIdx(rdIdx), .upd(upd), .lineMetaUpd(lineMetaUpd),
    .fillWrite(fillWrite), .fillForwardOnly(fillForwardOnly), .fillMeta(fillMeta),
    .nlMarkValid(nlMarkValid), .nlMarkSet(nlMarkSet)
  );

  bypassTable u_table (
    .clk(clk), .rstN(rstN), .rdIdx(rdIdx), .rdBypass(rdBypass), .upd(upd)
  );

  assign predBypass = lookupValid & rdBypass;
endmodule

// File: rtl/bypassPredictor_chk.sv
module bypassPredictor_chk
  import bpPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic              predBypass,
  input logic              fillValid,
  input logic              fillWrite,
  input logic              fillForwardOnly,
  input logic [META_W-1:0] fillMeta,
  input logic              nlMarkValid,
  input logic              nlMarkSet
);
  p_pred_needs_lookup_r2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !predBypass);

  p_fill_one_route_r6: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> $onehot({fillWrite, fillForwardOnly}));

  p_idle_no_route_r6: assert property (@(posedge clk) disable iff (!rstN)
    !fillValid |-> !fillWrite && !fillForwardOnly);

  p_fill_meta_fresh_r6: assert property (@(posedge clk) disable iff (!rstN)
    fillWrite |-> !fillMeta[REUSE_BIT]);

  p_mark_with_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    nlMarkValid == fillValid);

  p_mark_set_forward_r7: assert property (@(posedge clk) disable iff (!rstN)
    nlMarkSet |-> fillForwardOnly && nlMarkValid);
endmodule

bind bypassPredictor bypassPredictor_chk u_chk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .predBypass(predBypass),
  .fillValid(fillValid), .fillWrite(fillWrite), .fillForwardOnly(fillForwardOnly),
  .fillMeta(fillMeta), .nlMarkValid(nlMarkValid), .nlMarkSet(nlMarkSet)
);

// File: tb/bypassPredictor_bench.sv
`timescale 1ns/1ps
module bypassPredictor_bench;
  logic        clk = 0;
  logic        rstN = 0;
  logic        lookupValid = 0, lookupHit = 0;
  logic [31:0] lookupPc = 0, lookupAddr = 0;
  logic [6:0]  hitMeta = 0;
  logic        predBypass;
  logic [6:0]  lineMetaUpd;
  logic        evictValid = 0;
  logic [31:0] evictAddr = 0;
  logic [6:0]  evictMeta = 0;
  logic        fillValid = 0, fillPredBypass = 0, fillNlBypassBit = 0;
  logic [31:0] fillPc = 0, fillAddr = 0;
  logic        fillWrite, fillForwardOnly, nlMarkValid, nlMarkSet;
  logic [6:0]  fillMeta;

  int nTests = 0, nFail = 0;
  int model [128];
  bit finished = 0;

  always #2.5 clk = ~clk;

  bypassPredictor u_bypassPredictor (.*);

  function automatic logic [5:0] bh(input logic [31:0] pc);
    return pc[7:2] ^ pc[13:8] ^ pc[19:14] ^ pc[25:20] ^ pc[31:26];
  endfunction

  function automatic int bidx(input logic [31:0] pc, input logic [31:0] addr);
    return {25'd0, addr[6], bh(pc)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampC(input int v);
    return v < 0 ? 0 : (v > 15 ? 15 : v);
  endfunction

  // one cycle of events; counters settle at the next posedge
  task automatic step(input bit ev, input bit evReuse, input bit hit, input bit fl,
                      input bit flPred, input bit flNl, input logic [31:0] pc,
                      input logic [31:0] addr);
    int delta [128];
    foreach (delta[i]) delta[i] = 0;
    @(negedge clk);
    lookupValid = hit; lookupHit = hit; lookupPc = pc; lookupAddr = addr;
    hitMeta = {1'b0, bh(pc)};
    evictValid = ev; evictAddr = addr; evictMeta = {evReuse, bh(pc)};
    fillValid = fl; fillPc = pc; fillAddr = addr;
    fillPredBypass = flPred; fillNlBypassBit = flNl;
    #1;
    if (hit) check(lineMetaUpd == {1'b1, bh(pc)}, "R4 lineMetaUpd", lineMetaUpd, {1'b1, bh(pc)});
    if (fl) begin
      check(fillForwardOnly == (flPred & ~flNl), "R6 fillForwardOnly", fillForwardOnly, flPred & ~flNl);
      check(fillWrite == !(flPred & ~flNl), "R6 fillWrite", fillWrite, !(flPred & ~flNl));
      check(fillMeta == {1'b0, bh(pc)}, "R6 fillMeta", fillMeta, {1'b0, bh(pc)});
      check(nlMarkValid == 1'b1, "R7 nlMarkValid", nlMarkValid, 1);
      check(nlMarkSet == (flPred & ~flNl), "R7 nlMarkSet", nlMarkSet, flPred & ~flNl);
    end
    if (ev && !evReuse) delta[bidx(pc, addr)] += 1;
    if (hit) delta[bidx(pc, addr)] -= 1;
    if (fl && flNl) delta[bidx(pc, addr)] -= 2;
    foreach (model[i]) model[i] = clampC(model[i] + delta[i]);
    @(posedge clk); #1;
    lookupValid = 0; lookupHit = 0; evictValid = 0; fillValid = 0;
    fillPredBypass = 0; fillNlBypassBit = 0;
  endtask

  task automatic evictN(input int n, input bit reuse, input logic [31:0] pc, input logic [31:0] addr);
    for (int i = 0; i < n; i++) step(1, reuse, 0, 0, 0, 0, pc, addr);
  endtask

  task automatic hitN(input int n, input logic [31:0] pc, input logic [31:0] addr);
    for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0, 0, pc, addr);
  endtask

  task automatic probe(input logic [31:0] pc, input logic [31:0] addr, input string req);
    bit exp;
    @(negedge clk);
    lookupValid = 1; lookupHit = 0; lookupPc = pc; lookupAddr = addr;
    #1;
    exp = model[bidx(pc, addr)] >= 8;
    check(predBypass == exp, req, predBypass, exp);
    lookupValid = 0;
  endtask

  task automatic testReset();
    probe(32'h0000_0004, 32'h0, "R1 reset idx a");
    probe(32'h0000_0040, 32'h40, "R1 reset idx b");
    probe(32'hFFFF_FFFC, 32'h0, "R1 reset idx c");
    @(negedge clk); lookupValid = 0; #1;
    check(predBypass == 0, "R2 no lookup", predBypass, 0);
  endtask

  task automatic testTrainUp();
    logic [31:0] pc = 32'h0000_0004;
    evictN(7, 0, pc, 0); probe(pc, 0, "R3 below threshold at 7");
    evictN(1, 0, pc, 0); probe(pc, 0, "R3 threshold at 8");
    evictN(10, 0, pc, 0);
    hitN(7, pc, 0);      probe(pc, 0, "R3 ceiling 15 then 7 hits");
    hitN(1, pc, 0);      probe(pc, 0, "R4 hit drops to 7");
  endtask

  task automatic testReuseEvict();
    logic [31:0] pc = 32'h0000_0008;
    evictN(8, 1, pc, 0); probe(pc, 0, "R3 reused evictions ignored");
    evictN(8, 0, pc, 0); probe(pc, 0, "R3 fresh evictions train");
  endtask

  task automatic testHitFloor();
    logic [31:0] pc = 32'h0000_000C;
    hitN(3, pc, 0);
    evictN(7, 0, pc, 0); probe(pc, 0, "R4 floor at 0 after 7");
    evictN(1, 0, pc, 0); probe(pc, 0, "R4 floor at 0 after 8");
  endtask

  task automatic testMispredict();
    logic [31:0] pcD = 32'h0000_0010;
    logic [31:0] pcE = 32'h0000_0014;
    evictN(9, 0, pcD, 0);
    step(0, 0, 0, 1, 1, 1, pcD, 0); probe(pcD, 0, "R5 drop by two to 7");
    evictN(1, 0, pcD, 0);           probe(pcD, 0, "R5 back to 8");
    evictN(1, 0, pcE, 0);
    step(0, 0, 0, 1, 0, 1, pcE, 0);
    evictN(7, 0, pcE, 0);           probe(pcE, 0, "R5 floor after drop");
    evictN(1, 0, pcE, 0);           probe(pcE, 0, "R5 floor then 8");
  endtask

  task automatic testRouting();
    logic [31:0] pc = 32'h0000_0018;
    step(0, 0, 0, 1, 0, 0, pc, 0);
    step(0, 0, 0, 1, 1, 0, pc, 0);
    step(0, 0, 0, 1, 0, 1, pc, 0);
    step(0, 0, 0, 1, 1, 1, pc, 0);
    @(negedge clk); #1;
    check(fillWrite == 0 && fillForwardOnly == 0, "R6 idle routing", {fillWrite, fillForwardOnly}, 0);
    check(nlMarkValid == 0, "R7 idle mark", nlMarkValid, 0);
  endtask

  task automatic testCombine();
    logic [31:0] pc = 32'h0000_001C;
    evictN(8, 0, pc, 0);
    step(1, 0, 1, 0, 0, 0, pc, 0); probe(pc, 0, "R8 evict+hit net zero");
    step(1, 0, 1, 1, 0, 1, pc, 0); probe(pc, 0, "R8 net minus two");
    evictN(2, 0, pc, 0);           probe(pc, 0, "R8 recovered to 8");
  endtask

  task automatic testSetSplit();
    logic [31:0] pc = 32'h0000_0020;
    evictN(8, 0, pc, 32'h0000_0000);
    probe(pc, 32'h0000_0000, "R9 trained half");
    probe(pc, 32'h0000_0040, "R9 other half untouched");
  endtask

  task automatic testHashFold();
    logic [31:0] pcI = 32'h0000_1000;
    evictN(8, 0, pcI, 0);
    probe(pcI ^ 32'h104, 0, "R2 colliding PC shares counter");
    probe(pcI ^ 32'h4, 0, "R2 distinct hash separate");
  endtask

  initial begin
    foreach (model[i]) model[i] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    testReset();
    testTrainUp();
    testReuseEvict();
    testHitFloor();
    testMispredict();
    testRouting();
    testCombine();
    testSetSplit();
    testHashFold();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule